// File: doc/BRIEF.md
# Two-Level Instruction Fetch Cache

This block sits between an instruction fetch stage and a slow backing memory. It returns one fixed 40-bit instruction for each accepted fetch. A small level-one store with asynchronous read answers in a single cycle. A larger level-two store with a registered read answers a level-one miss in two cycles. When both levels miss, a whole line is requested from memory, and the line is written into both levels.

Each line takes a 32-byte aligned slot in the address space and holds six five-byte instructions at byte offsets 0, 5, 10, 15, 20 and 25. The last two bytes of the slot are padding, so no instruction ever crosses a line. Both levels are direct-mapped. Every fetch is cacheable. All state changes on the rising clock edge.

The fetch stage presents `fetch_req` and `fetch_pc`. While `fetch_stall` is high it must keep both unchanged. A request is accepted at a rising edge where `fetch_req` is high and `fetch_stall` is low. Its instruction appears on `insn` with `insn_valid` high for exactly the next cycle.

Top module: `icache_2lvl`

## Requirements
- R1: After reset `insn_valid` and `mem_req` are low, and every line of both levels is invalid, so the first fetch to any address is served from memory.
- R2: A level-one hit is accepted in the cycle it is presented (`fetch_stall` low), and `insn_valid` is high in the following cycle, one cycle after presentation.
- R3: A level-one miss that hits level two raises `fetch_stall` in the presentation cycle only. The instruction is valid two cycles after presentation. The level-one line is refilled at the same time, so a later fetch from that line hits in one cycle.
- R4: A miss in both levels raises `mem_req` two cycles after presentation. `mem_line_addr` equals `fetch_pc[31:5]`. `mem_req` and `mem_line_addr` are held until `mem_ack`, and the instruction is valid in the cycle after `mem_ack`. With a memory that acknowledges in its fourth request cycle, the fetch takes six cycles.
- R5: The instruction in slot k (byte offset 5k, k = 0..5) is bits [40k+39:40k] of `mem_line`.
- R6: Level one is indexed by `pc[10:5]` (2 kB) and level two by `pc[13:5]` (16 kB). Two lines 2 kB apart evict each other in level one only. Two lines 16 kB apart evict each other in both levels.
- R7: A one-cycle `inval` pulse clears every valid bit in both levels, so the next fetch to a previously cached line goes to memory.
- R8: `insn_valid` is a single-cycle pulse per accepted request, and it stays low while a miss is outstanding.
- R9: With no request presented, neither `insn_valid` nor `mem_req` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request |
| fetch_pc | input | 32 | Byte address of the instruction |
| fetch_stall | output | 1 | Request not accepted this cycle; hold inputs |
| insn_valid | output | 1 | `insn` holds the result of the last accepted fetch |
| insn | output | 40 | Fetched instruction |
| inval | input | 1 | Invalidate all lines of both levels |
| mem_req | output | 1 | Line fill request to memory |
| mem_line_addr | output | 27 | Line number to fill |
| mem_ack | input | 1 | Memory returns the line this cycle |
| mem_line | input | 240 | Line data, six instructions |

## Verification
The assertions take three things for granted about the inputs. A stalled requester keeps `fetch_req` high and `fetch_pc` unchanged. Every requested PC has a low-five-bit offset that is a multiple of five below 30. `inval` is pulsed only while the cache is idle and no request is presented. The bench's fetch task holds its address until it sees `fetch_stall` low and uses only legal offsets. The invalidate pulse is issued between fetches, after the previous instruction has been delivered. The memory model acknowledges only while `mem_req` is high, so the assertion on the held fill request is never driven outside its premise.

// File: rtl/icache_2lvl.sv
module icache_2lvl #(
  parameter int PC_W       = 32,
  parameter int INSN_W     = 40,
  parameter int LINE_INSNS = 6,
  parameter int LINE_BYTES = 32,
  parameter int L1_BYTES   = 2048,
  parameter int L2_BYTES   = 16384
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fetch_req,
  input  logic [PC_W-1:0]                  fetch_pc,
  output logic                             fetch_stall,
  output logic                             insn_valid,
  output logic [INSN_W-1:0]                insn,
  input  logic                             inval,
  output logic                             mem_req,
  output logic [PC_W-$clog2(LINE_BYTES)-1:0] mem_line_addr,
  input  logic                             mem_ack,
  input  logic [INSN_W*LINE_INSNS-1:0]     mem_line
);
  localparam int LINE_W     = INSN_W * LINE_INSNS;
  localparam int INSN_BYTES = INSN_W / 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int L1_LINES   = L1_BYTES / LINE_BYTES;
  localparam int L2_LINES   = L2_BYTES / LINE_BYTES;
  localparam int L1_IDX_W   = $clog2(L1_LINES);
  localparam int L2_IDX_W   = $clog2(L2_LINES);
  localparam int L1_TAG_W   = PC_W - OFF_W - L1_IDX_W;
  localparam int L2_TAG_W   = PC_W - OFF_W - L2_IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_L2, S_MEM} st_t;
  st_t st;

  logic [LINE_W-1:0]   l1_data [L1_LINES];
  logic [L1_TAG_W-1:0] l1_tag  [L1_LINES];
  logic [L1_LINES-1:0] l1_vld;
  logic [LINE_W-1:0]   l2_data [L2_LINES];
  logic [L2_TAG_W-1:0] l2_tag  [L2_LINES];
  logic [L2_LINES-1:0] l2_vld;

  logic [PC_W-1:0]     pc_q;
  logic [LINE_W-1:0]   l2_line_q;
  logic [L2_TAG_W-1:0] l2_tag_q;
  logic                l2_v_q;

  function automatic logic [INSN_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                             input logic [OFF_W-1:0] off);
    pick = '0;
    for (int i = 0; i < LINE_INSNS; i++)
      if (off == OFF_W'(i * INSN_BYTES)) pick = ln[i*INSN_W +: INSN_W];
  endfunction

  function automatic logic off_ok(input logic [OFF_W-1:0] off);
    off_ok = 1'b0;
    for (int i = 0; i < LINE_INSNS; i++)
      if (off == OFF_W'(i * INSN_BYTES)) off_ok = 1'b1;
  endfunction

  wire [L1_IDX_W-1:0] f_l1_idx = fetch_pc[OFF_W +: L1_IDX_W];
  wire [L1_TAG_W-1:0] f_l1_tag = fetch_pc[PC_W-1 -: L1_TAG_W];
  wire [L2_IDX_W-1:0] f_l2_idx = fetch_pc[OFF_W +: L2_IDX_W];
  wire [L1_IDX_W-1:0] q_l1_idx = pc_q[OFF_W +: L1_IDX_W];
  wire [L1_TAG_W-1:0] q_l1_tag = pc_q[PC_W-1 -: L1_TAG_W];
  wire [L2_IDX_W-1:0] q_l2_idx = pc_q[OFF_W +: L2_IDX_W];
  wire [L2_TAG_W-1:0] q_l2_tag = pc_q[PC_W-1 -: L2_TAG_W];

  wire l1_hit   = l1_vld[f_l1_idx] && (l1_tag[f_l1_idx] == f_l1_tag);
  wire l2_hit   = l2_v_q && (l2_tag_q == q_l2_tag);
  wire fill_l2  = (st == S_L2) && l2_hit;
  wire fill_mem = (st == S_MEM) && mem_ack;
  wire l1_we    = fill_l2 || fill_mem;
  wire [LINE_W-1:0] l1_wline = fill_mem ? mem_line : l2_line_q;

  assign fetch_stall   = (st == S_IDLE) ? (fetch_req && !l1_hit) :
                         (st == S_L2)   ? !l2_hit : !mem_ack;
  assign mem_req       = (st == S_MEM);
  assign mem_line_addr = pc_q[PC_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      insn_valid <= 1'b0;
      insn       <= '0;
      pc_q       <= '0;
      l1_vld     <= '0;
      l2_vld     <= '0;
      l2_v_q     <= 1'b0;
    end else begin
      insn_valid <= 1'b0;
      l2_v_q     <= l2_vld[f_l2_idx] && !inval;
      case (st)
        S_IDLE: if (fetch_req) begin
          if (l1_hit) begin
            insn       <= pick(l1_data[f_l1_idx], fetch_pc[OFF_W-1:0]);
            insn_valid <= 1'b1;
          end else begin
            pc_q <= fetch_pc;
            st   <= S_L2;
          end
        end
        S_L2: if (l2_hit) begin
          insn       <= pick(l2_line_q, pc_q[OFF_W-1:0]);
          insn_valid <= 1'b1;
          st         <= S_IDLE;
        end else begin
          st <= S_MEM;
        end
        S_MEM: if (mem_ack) begin
          insn       <= pick(mem_line, pc_q[OFF_W-1:0]);
          insn_valid <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (l1_we) l1_vld[q_l1_idx] <= 1'b1;
      if (fill_mem) l2_vld[q_l2_idx] <= 1'b1;
      if (inval) begin
        l1_vld <= '0;
        l2_vld <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    l2_line_q <= l2_data[f_l2_idx];
    l2_tag_q  <= l2_tag[f_l2_idx];
    if (l1_we) begin
      l1_data[q_l1_idx] <= l1_wline;
      l1_tag[q_l1_idx]  <= q_l1_tag;
    end
    if (fill_mem) begin
      l2_data[q_l2_idx] <= mem_line;
      l2_tag[q_l2_idx]  <= q_l2_tag;
    end
  end

  assert_l1_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && fetch_req && !fetch_stall) |=> insn_valid);
  assert_l2_refill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_l2 |=> (insn_valid && l1_vld[$past(q_l1_idx)] && st == S_IDLE));
  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_line_addr)));
  assert_mem_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (insn_valid && !mem_req));
  assert_inval_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> (l1_vld == '0 && l2_vld == '0));
  assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> !insn_valid);
  assert_hold_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_stall) |=> (fetch_req && $stable(fetch_pc)));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !fetch_req) |=> (!insn_valid && !mem_req));
  assert_legal_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> off_ok(fetch_pc[OFF_W-1:0]));
  assert_inval_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inval |-> (st == S_IDLE && !fetch_req));
endmodule

// File: tb/tb_icache_2lvl.sv
module tb_icache_2lvl;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetch_req = 1'b0;
  logic [31:0]  fetch_pc = '0;
  logic         fetch_stall;
  logic         insn_valid;
  logic [39:0]  insn;
  logic         inval = 1'b0;
  logic         mem_req;
  logic [26:0]  mem_line_addr;
  logic         mem_ack = 1'b0;
  logic [239:0] mem_line = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_2lvl dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .fetch_stall(fetch_stall), .insn_valid(insn_valid), .insn(insn),
    .inval(inval), .mem_req(mem_req), .mem_line_addr(mem_line_addr),
    .mem_ack(mem_ack), .mem_line(mem_line)
  );

  function automatic logic [39:0] exp_insn(input logic [31:0] pc);
    logic [7:0] k;
    k = 8'(pc[4:0] / 5'd5);
    return {5'b0, pc[31:5], k};
  endfunction

  function automatic logic [239:0] line_of(input logic [26:0] la);
    logic [239:0] l;
    for (int k = 0; k < 6; k++) l[k*40 +: 40] = {5'b0, la, 8'(k)};
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] pc, input int exp_lat, input string req);
    int n = 1;
    int mcnt = 0;
    int first_req = 0;
    @(negedge clk);
    fetch_req = 1'b1;
    fetch_pc  = pc;
    forever begin
      #1;
      if (mem_req) begin
        mcnt++;
        if (first_req == 0) first_req = n;
        if (mcnt == MEM_LAT) begin
          chk(mem_line_addr == pc[31:5], "R4", "fill line address",
              64'(mem_line_addr), 64'(pc[31:5]));
          mem_ack  = 1'b1;
          mem_line = line_of(mem_line_addr);
          #1;
        end
      end
      if (!fetch_stall || n > 40) break;
      @(negedge clk);
      n++;
      if (insn_valid) chk(1'b0, "R8", "valid while stalled", 64'(1), 64'(0));
    end
    @(negedge clk);
    fetch_req = 1'b0;
    mem_ack   = 1'b0;
    chk(n == exp_lat, req, "fetch latency", 64'(n), 64'(exp_lat));
    chk(insn_valid == 1'b1, req, "insn_valid", 64'(insn_valid), 64'(1));
    chk(insn == exp_insn(pc), "R5", "instruction", 64'(insn), 64'(exp_insn(pc)));
    if (exp_lat > 2)
      chk(first_req == 3, "R4", "mem_req start cycle", 64'(first_req), 64'(3));
    @(negedge clk);
    chk(!insn_valid && !mem_req, "R8", "single pulse", 64'({insn_valid, mem_req}), 64'(0));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!insn_valid, "R1", "insn_valid after reset", 64'(insn_valid), 64'(0));
    chk(!mem_req, "R1", "mem_req after reset", 64'(mem_req), 64'(0));
    chk(!fetch_stall, "R1", "stall idle", 64'(fetch_stall), 64'(0));
  endtask

  task automatic t_cold_and_slots;
    do_fetch(32'h0000_1000, 6, "R1");
    do_fetch(32'h0000_1005, 1, "R2");
    do_fetch(32'h0000_1019, 1, "R2");
    do_fetch(32'h0000_100F, 1, "R5");
  endtask

  task automatic t_l2_path;
    do_fetch(32'h0000_1800, 6, "R6");
    do_fetch(32'h0000_1014, 2, "R3");
    do_fetch(32'h0000_100A, 1, "R3");
    do_fetch(32'h0000_1805, 2, "R6");
  endtask

  task automatic t_l2_conflict;
    do_fetch(32'h0000_5000, 6, "R6");
    do_fetch(32'h0000_1000, 6, "R6");
  endtask

  task automatic t_inval;
    do_fetch(32'h0000_2000, 6, "R4");
    do_fetch(32'h0000_2000, 1, "R2");
    @(negedge clk);
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
    do_fetch(32'h0000_2005, 6, "R7");
  endtask

  task automatic t_idle;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!insn_valid && !mem_req, "R9", "idle quiet", 64'({insn_valid, mem_req}), 64'(0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cold_and_slots();
    t_l2_path();
    t_l2_conflict();
    t_inval();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule